// File: doc/BRIEF.md
# Byte-Splittable General Register File

This block is the general-purpose register storage of an execution datapath. It holds eight 16-bit registers behind one shared access path. In any cycle the datapath either reads one whole register onto the 16-bit read bus or writes one register from the write bus. The two operations are never meant to happen in the same cycle. When the datapath needs only a byte, it takes the half it wants from the full 16-bit read and ignores the other half. There is no separate byte-read control.

The lower four registers can also be written one byte at a time: the high half alone, the low half alone, or the full word. The upper four registers accept full-word writes only. A byte write aimed at one of them is dropped and reported on the error output.

A swap input exchanges the two bytes of the word on the path it applies to. On a read, the high byte of the register appears on bits 7:0. On a write, bus bits 7:0 go into the register's high half. This lets a high-byte operand be handled in the low-byte position, and it serves unaligned accesses.

Top module: `gpr_file`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero and drives the error output low.
- R2: With wr_en high and wr_be = 2'b11, the register chosen by sel takes the whole write word at the rising edge. A read (rd_en high, wr_en low) returns the current contents combinationally, in the same cycle.
- R3: wr_be = 2'b01 on a register with index 0 to 3 replaces bits 7:0 only. Bits 15:8 keep their value.
- R4: wr_be = 2'b10 on a register with index 0 to 3 replaces bits 15:8 only. Bits 7:0 keep their value.
- R5: wr_be = 2'b01 or 2'b10 on a register with index 4 to 7 leaves that register unchanged. The error output goes high in the next cycle.
- R6: A read with swap high returns the register's bits 7:0 on rdata[15:8] and its bits 15:8 on rdata[7:0].
- R7: A write with swap high exchanges the two bytes of wdata before the byte enables are applied. A high-byte write with swap therefore stores wdata[7:0] into bits 15:8.
- R8: When rd_en and wr_en are both high, the write is carried out, rdata is zero, and the error output goes high in the next cycle.
- R9: rdata is zero in every cycle that is not a plain read (rd_en low, or wr_en high).
- R10: wr_en with wr_be = 2'b00 changes no register and raises no error. The error output is low in the cycle after any legal access or idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Index of the register accessed |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wr_be | input | 2 | Byte enables: bit 1 selects the high half, bit 0 the low half |
| swap | input | 1 | Exchange the two bytes on the read or write path |
| wdata | input | 16 | Write data bus |
| rdata | output | 16 | Read data bus; zero when no plain read is taking place |
| err | output | 1 | Registered flag for an illegal request made in the previous cycle |

## Verification
The bench aims byte writes at both the last splittable register and the first word-only register. A design with the boundary off by one would either corrupt register 4 or reject legal byte writes to register 3. It also combines the swap input with high-byte and low-byte writes. A design that swapped after masking would put the wrong bus byte into the half being written. Cycles with read and write together check that the write still lands and that the bus stays quiet. A design that gave the read priority would lose the write, and one that forwarded the data would drive the bus. Writes with empty byte enables and word-only registers that are read back after a rejected write check that ignored requests really leave no trace.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  // Byte-enable codes on the write path: bit 1 = high half, bit 0 = low half.
  typedef enum logic [1:0] {
    BE_NONE = 2'b00,
    BE_LO   = 2'b01,
    BE_HI   = 2'b10,
    BE_WORD = 2'b11
  } be_t;

  // A partial write touches exactly one half.
  function automatic logic is_partial(input logic [1:0] be);
    return (be == BE_LO) || (be == BE_HI);
  endfunction

endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int NREG   = 8,
  parameter int NSPLIT = 4,
  localparam int AW    = $clog2(NREG)
) (
  input  logic                       wr_en,
  input  logic [AW-1:0]              sel,
  input  logic [1:0]                 wr_be,
  output logic [NREG-1:0][1:0]       lane_we,
  output logic                       bad_partial
);
  import gpr_pkg::*;

  logic wordonly_target;
  assign wordonly_target = int'(sel) >= NSPLIT;
  assign bad_partial     = wr_en && wordonly_target && is_partial(wr_be);

  // Per-register lane enables; the register kind is fixed per index.
  for (genvar i = 0; i < NREG; i++) begin : g_lane
    logic hit;
    assign hit = wr_en && (int'(sel) == i);
    if (i < NSPLIT) begin : g_split
      assign lane_we[i] = hit ? wr_be : 2'b00;
    end else begin : g_word
      assign lane_we[i] = (hit && wr_be == BE_WORD) ? 2'b11 : 2'b00;
    end
  end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int HW  = DW / 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NREG-1:0][1:0]      lane_we,
  input  logic [DW-1:0]             wword,
  output logic [NREG-1:0][DW-1:0]   words
);

  // Storage: one flop word per register, written half by half.
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [HW-1:0] lo_q, hi_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lane_we[i][0]) lo_q <= wword[HW-1:0];
        if (lane_we[i][1]) hi_q <= wword[DW-1:HW];
      end
    end
    assign words[i] = {hi_q, lo_q};
  end

endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int HW  = DW / 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [NREG-1:0][DW-1:0]   words,
  input  logic [AW-1:0]             sel,
  input  logic                      rd_en,
  input  logic                      wr_en,
  input  logic                      swap,
  output logic [DW-1:0]             rdata
);

  logic [DW-1:0] picked;

  always_comb begin
    picked = words[sel];
    if (!rd_en || wr_en)
      rdata = '0;
    else if (swap)
      rdata = {picked[HW-1:0], picked[DW-1:HW]};
    else
      rdata = picked;
  end

endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int DW     = 16,
  parameter int NREG   = 8,
  parameter int NSPLIT = 4,
  localparam int HW    = DW / 2,
  localparam int AW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] sel,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_be,
  input  logic          swap,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err
);

  logic [NREG-1:0][1:0]    lane_we;
  logic [NREG-1:0][DW-1:0] words;
  logic                    bad_partial;
  logic [DW-1:0]           wword;
  logic                    err_q;

  // Byte exchange on the write path happens before lane masking.
  assign wword = swap ? {wdata[HW-1:0], wdata[DW-1:HW]} : wdata;

  gpr_wr_decode #(.NREG(NREG), .NSPLIT(NSPLIT)) u_dec (
    .wr_en       (wr_en),
    .sel         (sel),
    .wr_be       (wr_be),
    .lane_we     (lane_we),
    .bad_partial (bad_partial)
  );

  gpr_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .lane_we (lane_we),
    .wword   (wword),
    .words   (words)
  );

  gpr_rd_mux #(.DW(DW), .NREG(NREG)) u_rmux (
    .words (words),
    .sel   (sel),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .swap  (swap),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (rd_en && wr_en) || bad_partial;
  end

  assign err = err_q;

endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int DW     = 16,
  parameter int NREG   = 8,
  parameter int NSPLIT = 4,
  localparam int AW    = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] sel,
  input logic          rd_en,
  input logic          wr_en,
  input logic [1:0]    wr_be,
  input logic          swap,
  input logic [DW-1:0] rdata,
  input logic          err
);

  logic wo_partial;
  assign wo_partial = wr_en && (int'(sel) >= NSPLIT) &&
                      (wr_be == 2'b01 || wr_be == 2'b10);

  p_conflict_err_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en && wr_en |=> err);

  p_partial_err_r5: assert property (@(posedge clk) disable iff (rst)
    wo_partial |=> err);

  p_quiet_err_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en) && !wo_partial |=> !err);

  p_idle_bus_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || wr_en) |-> rdata == '0);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && rd_en && !wr_en |-> rdata == '0);

  // R2: with no write in between, a repeated read returns the same word.
  p_read_hold_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en && !wr_en && $past(rd_en && !wr_en) && !$past(rst) &&
    $stable(sel) && $stable(swap) |-> $stable(rdata));

endmodule

bind gpr_file gpr_file_chk #(.DW(DW), .NREG(NREG), .NSPLIT(NSPLIT)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .sel   (sel),
  .rd_en (rd_en),
  .wr_en (wr_en),
  .wr_be (wr_be),
  .swap  (swap),
  .rdata (rdata),
  .err   (err)
);

// File: tb/gpr_file_tb_top.sv
module gpr_file_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  sel = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = '0;
  logic        swap = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  gpr_file dut_i (
    .clk(clk), .rst(rst), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_be(wr_be), .swap(swap), .wdata(wdata), .rdata(rdata), .err(err)
  );

  // Reference model and scoreboard queues.
  logic [15:0] mdl [8];
  logic        pend_err = 1'b0;
  string       pend_tag = "R1";
  logic [15:0] q_rd [$];
  logic        q_err [$];
  string       q_rtag [$];
  string       q_etag [$];

  function automatic logic [15:0] bswap(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  task automatic op(input logic r, input logic w, input logic [1:0] be,
                    input logic [2:0] s, input logic sw, input logic [15:0] d,
                    input string tag);
    logic bad;
    logic [15:0] dd;
    @(negedge clk);
    rd_en = r; wr_en = w; wr_be = be; sel = s; swap = sw; wdata = d;
    q_rd.push_back((r && !w) ? (sw ? bswap(mdl[s]) : mdl[s]) : 16'h0000);
    q_err.push_back(pend_err);
    q_rtag.push_back(tag);
    q_etag.push_back(pend_tag);
    bad = w && (s >= 3'd4) && (be == 2'b01 || be == 2'b10);
    pend_err = (r && w) || bad;
    pend_tag = tag;
    if (w && !bad) begin
      dd = sw ? bswap(d) : d;
      if (be[0]) mdl[s][7:0]  = dd[7:0];
      if (be[1]) mdl[s][15:8] = dd[15:8];
    end
  endtask

  task automatic rd(input logic [2:0] s, input logic sw, input string tag);
    op(1'b1, 1'b0, 2'b00, s, sw, 16'h0000, tag);
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] be, input logic sw,
                    input logic [15:0] d, input string tag);
    op(1'b0, 1'b1, be, s, sw, d, tag);
  endtask

  // Monitor: samples a quarter period after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q_rd.size() > 0) begin
        logic [15:0] erd;
        logic        eer;
        string       rt, et;
        erd = q_rd.pop_front();
        eer = q_err.pop_front();
        rt  = q_rtag.pop_front();
        et  = q_etag.pop_front();
        checks++;
        if (rdata !== erd) begin
          errors++;
          $display("FAIL %s rdata actual %h expected %h", rt, rdata, erd);
        end
        checks++;
        if (err !== eer) begin
          errors++;
          $display("FAIL %s err actual %b expected %b", et, err, eer);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset contents
    rd(3'd0, 1'b0, "R1");
    rd(3'd7, 1'b0, "R1");
    // R2: full-word writes to every register, then read back
    for (int i = 0; i < 8; i++) wr(3'(i), 2'b11, 1'b0, 16'h1357 + 16'(i * 16'h1111), "R2");
    for (int i = 0; i < 8; i++) rd(3'(i), 1'b0, "R2");
    // R3: low-byte writes to splittable registers, including the last one
    wr(3'd1, 2'b01, 1'b0, 16'hABCD, "R3");
    rd(3'd1, 1'b0, "R3");
    wr(3'd3, 2'b01, 1'b0, 16'h00EE, "R3");
    rd(3'd3, 1'b0, "R3");
    // R4: high-byte writes
    wr(3'd2, 2'b10, 1'b0, 16'hABCD, "R4");
    rd(3'd2, 1'b0, "R4");
    wr(3'd0, 2'b10, 1'b0, 16'h7700, "R4");
    rd(3'd0, 1'b0, "R4");
    // R5: byte writes to word-only registers are rejected
    wr(3'd4, 2'b01, 1'b0, 16'hFFFF, "R5");
    rd(3'd4, 1'b0, "R5");
    wr(3'd7, 2'b10, 1'b0, 16'hFFFF, "R5");
    rd(3'd7, 1'b0, "R5");
    // R6: swapped reads
    rd(3'd3, 1'b1, "R6");
    rd(3'd6, 1'b1, "R6");
    // R7: swapped writes
    wr(3'd5, 2'b11, 1'b1, 16'h1234, "R7");
    rd(3'd5, 1'b0, "R7");
    wr(3'd1, 2'b10, 1'b1, 16'h99C3, "R7");
    rd(3'd1, 1'b0, "R7");
    wr(3'd2, 2'b01, 1'b1, 16'h5A00, "R7");
    rd(3'd2, 1'b0, "R7");
    // R8: read and write together
    op(1'b1, 1'b1, 2'b11, 3'd6, 1'b0, 16'hBEEF, "R8");
    rd(3'd6, 1'b0, "R8");
    // R9: idle cycle keeps the bus at zero
    op(1'b0, 1'b0, 2'b11, 3'd6, 1'b0, 16'h0000, "R9");
    op(1'b0, 1'b0, 2'b00, 3'd1, 1'b1, 16'h0000, "R9");
    // R10: empty byte enables write nothing and raise no error
    wr(3'd4, 2'b00, 1'b0, 16'h0F0F, "R10");
    rd(3'd4, 1'b0, "R10");
    wr(3'd0, 2'b00, 1'b0, 16'h0F0F, "R10");
    rd(3'd0, 1'b0, "R10");
    rd(3'd0, 1'b0, "R10");
    wait (q_rd.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule